// File: doc/BRIEF.md
# Dual-Direction Bit-Serial CRC Engine for an SPI Port

This block sits next to the shift register of an SPI port. It keeps two running CRCs side by side. The transmit lane follows the bits that leave the port and the receive lane follows the bits that arrive. Each lane moves forward by one step for every serial bit that its own strobe marks. Software can therefore read a partial checksum at any point in a transfer.

The CRC width follows the frame size of the port at run time. In 8-bit frames the lane runs an 8-bit CRC that uses the low byte of the polynomial input. In 16-bit frames it runs a 16-bit CRC that uses the whole input. The surrounding logic enables the engine with one level control. Each 0-to-1 transition of that control zeroes both lanes, so every transfer starts from a clean seed. The two results are read back through a simple 32-bit read port with a one-bit select.

Top module: `spi_dual_crc`

## Requirements
- R1: The TX lane advances only on cycles where `tx_bit_vld` is high. The RX lane advances only on cycles where `rx_bit_vld` is high. A strobe on one lane never changes the other lane.
- R2: One step works MSB first. Take the feedback as the lane's top bit (bit W-1) XOR the data bit. Shift the lane left by one and put 0 in bit 0. If the feedback is 1, XOR the polynomial into the result.
- R3: A strobe registered at a clock edge is visible on `rd_data` right after that edge. A read in the middle of a transfer returns the partial CRC of the bits sent so far. For example, one data bit of 1 from a zero lane gives the polynomial itself.
- R4: With `frame16` = 0, W is 8 and only `poly[7:0]` is used. The result sits in bits [7:0] and bits [15:8] of the lane read as zero after every step.
- R5: With `frame16` = 1, W is 16 and the whole `poly[15:0]` is used. The result fills bits [15:0].
- R6: An active-low `rst_n` clears both lanes to 0x0000 at once, with no clock edge needed.
- R7: At the first clock edge after `crc_en` goes from 0 to 1, both lanes become zero. Any strobe presented in that cycle is discarded.
- R8: While `crc_en` is 0, strobes are ignored and both lanes keep their values.
- R9: `rd_sel` = 0 returns the TX lane and `rd_sel` = 1 returns the RX lane, both in `rd_data[15:0]`. `rd_data[31:16]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_en | input | 1 | CRC enable; a rising edge clears both lanes |
| frame16 | input | 1 | 0: 8-bit frames and CRC; 1: 16-bit frames and CRC |
| poly | input | 16 | Generator polynomial (low byte used in 8-bit mode) |
| tx_bit_vld | input | 1 | Strobe: a transmitted bit is present |
| tx_bit | input | 1 | Transmitted serial bit |
| rx_bit_vld | input | 1 | Strobe: a received bit is present |
| rx_bit | input | 1 | Received serial bit |
| rd_sel | input | 1 | Read select: 0 TX lane, 1 RX lane |
| rd_data | output | 32 | Selected lane, zero-extended |

## Verification
The bench builds the block with its default parameters: a 16-bit wide CRC, an 8-bit narrow CRC and a 32-bit read word. These defaults cover both run-time widths. They also allow two standard check values over the ASCII string "123456789": 0xF4 for the 8-bit CRC with polynomial 0x07 and 0x31C3 for the 16-bit CRC with polynomial 0x1021, both seeded at zero. A behavioural model compares both lanes through the read port on every cycle. This covers the discarded strobe in the enable-rise cycle, strobes while disabled, and one-lane-only traffic.

// File: rtl/spi_crc_pkg.sv
package spi_crc_pkg;

    localparam int unsigned CRC_WIDE_W   = 16;
    localparam int unsigned CRC_NARROW_W = 8;
    localparam int unsigned NUM_LANES    = 2;
    localparam int unsigned LANE_TX      = 0;
    localparam int unsigned LANE_RX      = 1;

    typedef logic [CRC_WIDE_W-1:0] crc_word_t;

    typedef enum logic {
        FRAME_8  = 1'b0,
        FRAME_16 = 1'b1
    } frame_e;

    typedef struct packed {
        crc_word_t crc;
    } lane_state_t;

    typedef struct packed {
        logic en_q;
    } ctl_state_t;

    // One bit-serial step over an active width of w bits; bits at and above w are zero.
    function automatic crc_word_t crc_step(input crc_word_t cur,
                                           input logic      din,
                                           input crc_word_t poly,
                                           input int unsigned w);
        crc_word_t nxt;
        logic      fb;
        fb  = cur[w-1] ^ din;
        nxt = {cur[CRC_WIDE_W-2:0], 1'b0};
        if (fb) begin
            nxt = nxt ^ poly;
        end
        for (int unsigned i = 0; i < CRC_WIDE_W; i++) begin
            if (i >= w) begin
                nxt[i] = 1'b0;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/spi_crc_ctrl.sv
module spi_crc_ctrl
    import spi_crc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic crc_en,
    output logic clr,
    output logic run
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.en_q = crc_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clr = crc_en & ~st_q.en_q;
    assign run = crc_en &  st_q.en_q;

endmodule

// File: rtl/spi_crc_lane.sv
module spi_crc_lane
    import spi_crc_pkg::*;
#(
    parameter int unsigned WIDE_W   = CRC_WIDE_W,
    parameter int unsigned NARROW_W = CRC_NARROW_W
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr,
    input  logic      run,
    input  logic      upd,
    input  logic      din,
    input  logic      wide,
    input  crc_word_t poly,
    output crc_word_t crc
);

    localparam int unsigned NARROW_SHIFT = WIDE_W - NARROW_W;

    lane_state_t st_d, st_q;
    crc_word_t   poly_eff;
    int unsigned width_eff;

    always_comb begin
        if (wide == FRAME_16) begin
            width_eff = WIDE_W;
            poly_eff  = poly;
        end else begin
            width_eff = NARROW_W;
            poly_eff  = (poly << NARROW_SHIFT) >> NARROW_SHIFT;
        end
    end

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.crc = '0;
        end else if (run && upd) begin
            st_d.crc = crc_step(st_q.crc, din, poly_eff, width_eff);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc = st_q.crc;

endmodule

// File: rtl/spi_crc_rdmux.sv
module spi_crc_rdmux
    import spi_crc_pkg::*;
#(
    parameter int unsigned RD_W = 32
) (
    input  logic            rd_sel,
    input  crc_word_t       tx_crc,
    input  crc_word_t       rx_crc,
    output logic [RD_W-1:0] rd_data
);

    localparam int unsigned PAD_W = RD_W - CRC_WIDE_W;

    always_comb begin
        rd_data = {{PAD_W{1'b0}}, (rd_sel ? rx_crc : tx_crc)};
    end

endmodule

// File: rtl/spi_dual_crc.sv
module spi_dual_crc
    import spi_crc_pkg::*;
#(
    parameter int unsigned RD_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            crc_en,
    input  logic            frame16,
    input  logic [15:0]     poly,
    input  logic            tx_bit_vld,
    input  logic            tx_bit,
    input  logic            rx_bit_vld,
    input  logic            rx_bit,
    input  logic            rd_sel,
    output logic [RD_W-1:0] rd_data
);

    logic                 clr;
    logic                 run;
    logic [NUM_LANES-1:0] lane_upd;
    logic [NUM_LANES-1:0] lane_din;
    crc_word_t            lane_crc [NUM_LANES];
    crc_word_t            tx_crc;
    crc_word_t            rx_crc;

    assign lane_upd[LANE_TX] = tx_bit_vld;
    assign lane_upd[LANE_RX] = rx_bit_vld;
    assign lane_din[LANE_TX] = tx_bit;
    assign lane_din[LANE_RX] = rx_bit;

    spi_crc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .crc_en (crc_en),
        .clr    (clr),
        .run    (run)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        spi_crc_lane #(
            .WIDE_W   (CRC_WIDE_W),
            .NARROW_W (CRC_NARROW_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .run   (run),
            .upd   (lane_upd[g]),
            .din   (lane_din[g]),
            .wide  (frame16),
            .poly  (poly),
            .crc   (lane_crc[g])
        );
    end

    assign tx_crc = lane_crc[LANE_TX];
    assign rx_crc = lane_crc[LANE_RX];

    spi_crc_rdmux #(
        .RD_W (RD_W)
    ) u_rdmux (
        .rd_sel  (rd_sel),
        .tx_crc  (tx_crc),
        .rx_crc  (rx_crc),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/spi_dual_crc_chk.sv
module spi_dual_crc_chk
    import spi_crc_pkg::*;
#(
    parameter int unsigned RD_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            crc_en,
    input logic            frame16,
    input logic            tx_bit_vld,
    input logic            rx_bit_vld,
    input crc_word_t       tx_crc,
    input crc_word_t       rx_crc,
    input logic [RD_W-1:0] rd_data
);

    AST_EN_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_en) |=> (tx_crc == '0) && (rx_crc == '0)); // R7

    AST_OFF_HOLDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_en |=> $stable(tx_crc)); // R8

    AST_OFF_HOLDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_en |=> $stable(rx_crc)); // R8

    AST_IDLE_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_en && $past(crc_en) && !tx_bit_vld) |=> $stable(tx_crc)); // R1

    AST_IDLE_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_en && $past(crc_en) && !rx_bit_vld) |=> $stable(rx_crc)); // R1

    AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_en && !frame16 && tx_bit_vld) |=> (tx_crc[15:8] == 8'h00)); // R4

    AST_READ_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[RD_W-1:CRC_WIDE_W] == '0); // R9

endmodule

bind spi_dual_crc spi_dual_crc_chk #(.RD_W(RD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .crc_en     (crc_en),
    .frame16    (frame16),
    .tx_bit_vld (tx_bit_vld),
    .rx_bit_vld (rx_bit_vld),
    .tx_crc     (tx_crc),
    .rx_crc     (rx_crc),
    .rd_data    (rd_data)
);

// File: tb/spi_dual_crc_bench.sv
module spi_dual_crc_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        crc_en;
    logic        frame16;
    logic [15:0] poly;
    logic        tx_bit_vld, tx_bit, rx_bit_vld, rx_bit;
    logic        rd_sel;
    logic [31:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    int m_tx, m_rx;
    bit m_en_prev;

    always #10 clk = ~clk;

    spi_dual_crc u_spi_dual_crc (
        .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .frame16(frame16), .poly(poly),
        .tx_bit_vld(tx_bit_vld), .tx_bit(tx_bit), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic int model_step(int c, bit b, int p, bit wide);
        int w, mask, top;
        w    = wide ? 16 : 8;
        mask = (1 << w) - 1;
        top  = (c >> (w - 1)) & 1;
        c    = (c * 2) & mask;
        if ((top ^ int'(b)) == 1) c = c ^ (p & mask);
        return c;
    endfunction

    // Behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tx <= 0; m_rx <= 0; m_en_prev <= 1'b0;
        end else begin
            m_en_prev <= crc_en;
            if (crc_en && !m_en_prev) begin
                m_tx <= 0; m_rx <= 0;
            end else if (crc_en) begin
                if (tx_bit_vld) m_tx <= model_step(m_tx, tx_bit, int'(poly), frame16);
                if (rx_bit_vld) m_rx <= model_step(m_rx, rx_bit, int'(poly), frame16);
            end
        end
    end

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Per-cycle compare against the model through the read port (R2, R3)
    always @(negedge clk) begin
        if (!done) begin
            rd_sel = 1'b0; #1;
            chk(rd_data, m_tx[31:0], "R2 R3 per-cycle TX lane");
            rd_sel = 1'b1; #1;
            chk(rd_data, m_rx[31:0], "R2 R3 per-cycle RX lane");
        end
    end

    task automatic read_both(input logic [31:0] etx, input logic [31:0] erx, input string tag);
        rd_sel = 1'b0; #1; chk(rd_data, etx, {tag, " TX"});
        rd_sel = 1'b1; #1; chk(rd_data, erx, {tag, " RX"});
    endtask

    task automatic send_byte(input logic [7:0] tb, input logic [7:0] rb, input bit ton, input bit ron);
        for (int i = 7; i >= 0; i--) begin
            @(posedge clk); #2;
            tx_bit_vld = ton; tx_bit = tb[i];
            rx_bit_vld = ron; rx_bit = rb[i];
        end
    endtask

    task automatic finish_strobes();
        @(posedge clk); #2;
        tx_bit_vld = 1'b0; rx_bit_vld = 1'b0;
        #3;
    endtask

    task automatic send_str(input bit ton, input bit ron, input logic [7:0] rx_xor);
        string s;
        s = "123456789";
        for (int k = 0; k < 9; k++) send_byte(s[k], s[k] ^ rx_xor, ton, ron);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; crc_en = 1'b0; frame16 = 1'b0; poly = 16'h0000;
        tx_bit_vld = 1'b0; tx_bit = 1'b0; rx_bit_vld = 1'b0; rx_bit = 1'b0; rd_sel = 1'b0;
        repeat (3) @(posedge clk);
        #5 read_both(32'h0, 32'h0, "R6 reset value");
        @(posedge clk); #2 rst_n = 1'b1;

        // 8-bit mode known vector on TX, different data on RX
        @(posedge clk); #2 crc_en = 1'b1; poly = 16'hFF07; // high byte must be ignored in 8-bit mode
        send_str(1'b1, 1'b1, 8'hA5);
        finish_strobes();
        rd_sel = 1'b0; #1 chk(rd_data, 32'h0000_00F4, "R4 R9 8-bit check value");

        // disabled: strobes ignored
        @(posedge clk); #2 crc_en = 1'b0;
        send_byte(8'h5A, 8'hC3, 1'b1, 1'b1);
        finish_strobes();
        rd_sel = 1'b0; #1 chk(rd_data, 32'h0000_00F4, "R8 TX held while disabled");

        // switch to 16-bit, enable with a strobe in the rise cycle
        @(posedge clk); #2 frame16 = 1'b1; poly = 16'h1021;
        @(posedge clk); #2 crc_en = 1'b1; tx_bit_vld = 1'b1; tx_bit = 1'b1; rx_bit_vld = 1'b1; rx_bit = 1'b1;
        finish_strobes();
        read_both(32'h0, 32'h0, "R7 enable rise clears");

        // TX only, 16-bit known vector
        send_str(1'b1, 1'b0, 8'h00);
        finish_strobes();
        read_both(32'h0000_31C3, 32'h0, "R5 R1 16-bit check value, RX untouched");

        // RX only
        for (int k = 0; k < 4; k++) send_byte(8'h00, 8'h3C + 8'(k), 1'b0, 1'b1);
        finish_strobes();
        rd_sel = 1'b0; #1 chk(rd_data, 32'h0000_31C3, "R1 TX untouched by RX traffic");

        // intermediate readback
        @(posedge clk); #2 crc_en = 1'b0;
        @(posedge clk); #2 crc_en = 1'b1;
        @(posedge clk); #2 tx_bit_vld = 1'b1; tx_bit = 1'b1;
        @(posedge clk); #2 tx_bit = 1'b0;
        #3 rd_sel = 1'b0; #1 chk(rd_data, 32'h0000_1021, "R3 partial after one bit");
        finish_strobes();
        rd_sel = 1'b0; #1 chk(rd_data, 32'h0000_2042, "R3 partial after two bits");

        // 8-bit partial: poly low byte only
        @(posedge clk); #2 crc_en = 1'b0; frame16 = 1'b0; poly = 16'hAB07;
        @(posedge clk); #2 crc_en = 1'b1;
        @(posedge clk); #2 rx_bit_vld = 1'b1; rx_bit = 1'b1;
        finish_strobes();
        rd_sel = 1'b1; #1 chk(rd_data, 32'h0000_0007, "R4 narrow poly on RX");

        // mid-run reset
        send_byte(8'hF0, 8'h0F, 1'b1, 1'b1);
        @(posedge clk); #2 rst_n = 1'b0;
        #1 read_both(32'h0, 32'h0, "R6 asynchronous reset");
        tx_bit_vld = 1'b0; rx_bit_vld = 1'b0;
        @(posedge clk); #2 rst_n = 1'b1;
        repeat (2) @(posedge clk);

        #5 done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule